// File: doc/BRIEF.md
# Run-Time Reconfigurable Instruction Cache

This block is a read-only instruction cache whose geometry can be changed while the chip runs. Its storage is four equal 2 KB banks. A banks-enabled setting of one, two or four banks sets the capacity to 2, 4 or 8 KB, and the disabled banks hold nothing. The enabled banks are grouped into one, two or four ways. When there are fewer ways than enabled banks, the banks of one way are joined end to end. The address bits just above the set index then pick the bank inside the way, and the stored tag always covers those bits, so two addresses never alias. The logical line can be 16, 32 or 64 bytes. The physical line is always 16 bytes, so a longer line is filled with two or four refill beats.

A processor drives fetch addresses and receives 32-bit instruction words, each with a flag that tells a hit from a miss. A hit answers one cycle after the fetch is accepted. A miss issues line refills to memory in ascending address order, writes them into a victim way chosen round-robin per set, and then returns the requested word. Any configuration write clears every valid bit and every round-robin pointer in a single cycle. Two 32-bit counters record hits and misses.

Top module: `cfg_icache`

## Requirements
- R1: After reset, fetch_ready is 1, resp_valid and mem_req_valid are 0, and both counters are 0. The cache is empty and set to 2 KB, direct-mapped, with 16-byte lines: addresses 0x100 and 0x900, which share index bits [10:4], evict each other.
- R2: A fetch is accepted on a clock edge where fetch_valid and fetch_ready are 1 and cfg_write is 0. On a hit, resp_valid and resp_hit are 1 in the next cycle and resp_data is the word at fetch_addr[31:2].
- R3: On a miss, mem_req_valid rises in the next cycle with a 16-byte-aligned mem_req_addr. Each request is held until a cycle with mem_resp_valid, whose mem_resp_data carries word i of the 16 bytes at bits [32i+31:32i]. One cycle after the last beat, resp_valid is 1 with resp_hit 0 and the requested word.
- R4: cfg_line 0/1/2 selects 16/32/64-byte lines, and code 3 means 64. A miss refills every 16-byte part of the aligned logical line, lowest address first. After that, every word of the logical line hits.
- R5: cfg_size 0/1/2 enables 1/2/4 banks (2/4/8 KB), and code 3 means 4 banks. When there are fewer ways than banks, address bits [12:11] select the bank inside a way. A direct-mapped cache therefore holds as many addresses with equal bits [10:4] as it has enabled banks.
- R6: cfg_ways 0/1/2 selects 1/2/4 ways, and code 3 means 4. The way count is limited to the number of enabled banks, so a 2 KB setting is always direct-mapped.
- R7: In multi-way modes the victim of each set follows a round-robin pointer that starts at way 0 and advances by one per fill. Hits do not move the pointer.
- R8: A cfg_write sampled while fetch_ready is 1 loads the new geometry and invalidates every line and pointer at that edge. A fetch presented in the same cycle is dropped. A cfg_write sampled while a refill is in progress is ignored.
- R9: Each accepted fetch adds 1 to hit_count if it hits, or to miss_count if it misses, at its acceptance edge.
- R10: cnt_clear sets both counters to 0 at the next edge and takes priority over a same-cycle increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write | input | 1 | Geometry write strobe |
| cfg_size | input | 2 | Enabled-bank code |
| cfg_ways | input | 2 | Associativity code |
| cfg_line | input | 2 | Logical line length code |
| fetch_valid | input | 1 | Fetch request |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Cache can accept a fetch |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Response came from a hit |
| resp_data | output | 32 | Instruction word |
| mem_req_valid | output | 1 | Refill request pending |
| mem_req_addr | output | 32 | 16-byte-aligned refill address |
| mem_resp_valid | input | 1 | Refill beat returned |
| mem_resp_data | input | 128 | Refill beat contents |
| cnt_clear | input | 1 | Clear both counters |
| hit_count | output | 32 | Hits since last clear |
| miss_count | output | 32 | Misses since last clear |

## Verification
The bench builds conflict chains on one set index. Per mode, it checks that the number of addresses that can live together matches the enabled banks and ways. A wrong bank-select or tag width would show up as early evictions or false hits. It replays eviction sequences in which only a correct round-robin pointer that ignores hits gives the expected pattern. It logs the order of refill addresses for 32- and 64-byte lines, and it presents a requested word that is not in the first beat, so a wrong critical-word pick returns wrong data. It also checks clamped codes, a geometry write that is ignored during a refill (the refilled line must still hit), and a fetch that shares its cycle with a geometry write (it must be dropped).

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int ADDR_W      = 32;
    localparam int WORD_W      = 32;
    localparam int NUM_BANKS   = 4;
    localparam int BANK_BYTES  = 2048;
    localparam int PLINE_BYTES = 16;
    localparam int MAX_SUB_LG  = 2;

    localparam int OFF_W    = $clog2(PLINE_BYTES);
    localparam int LINES    = BANK_BYTES / PLINE_BYTES;
    localparam int IDX_W    = $clog2(LINES);
    localparam int TAG_LSB  = OFF_W + IDX_W;
    localparam int TAG_W    = ADDR_W - TAG_LSB;
    localparam int BANK_W   = $clog2(NUM_BANKS);
    localparam int LINE_W   = PLINE_BYTES * 8;
    localparam int WSEL_W   = $clog2(PLINE_BYTES / (WORD_W / 8));
    localparam int PL_W     = ADDR_W - OFF_W;
    localparam int SUB_W    = MAX_SUB_LG;

    // log2 of enabled banks, ways and sub-lines per logical line
    typedef struct packed {
        logic [1:0] size_lg;
        logic [1:0] ways_lg;
        logic [1:0] line_lg;
    } geom_t;

    typedef enum logic {ST_IDLE, ST_REFILL} ctl_state_e;

    function automatic logic [1:0] clamp_code(input logic [1:0] c);
        return (c == 2'd3) ? 2'd2 : c;
    endfunction

    function automatic logic [1:0] lg_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic geom_t make_geom(input logic [1:0] s,
                                        input logic [1:0] w,
                                        input logic [1:0] l);
        geom_t g;
        g.size_lg = clamp_code(s);
        g.ways_lg = (clamp_code(w) > g.size_lg) ? g.size_lg : clamp_code(w);
        g.line_lg = clamp_code(l);
        return g;
    endfunction

endpackage

// File: rtl/ic_cfg_reg.sv
module ic_cfg_reg
    import icache_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic [1:0] size_code,
    input  logic [1:0] ways_code,
    input  logic [1:0] line_code,
    output geom_t      geom
);
    always_ff @(posedge clk) begin
        if (rst) begin
            geom <= '0;
        end else if (take) begin
            geom <= make_geom(size_code, ways_code, line_code);
        end
    end
endmodule

// File: rtl/ic_store.sv
module ic_store
    import icache_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int NL = LINES
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [NB-1:0]              rd_valid,
    output logic [NB-1:0][TAG_W-1:0]   rd_tag,
    output logic [NB-1:0][LINE_W-1:0]  rd_line,
    input  logic [IDX_W-1:0]           rr_rd_idx,
    output logic [BANK_W-1:0]          rr_rd_val,
    input  logic                       wr_en,
    input  logic [BANK_W-1:0]          wr_bank,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [LINE_W-1:0]          wr_line,
    input  logic                       rr_wr_en,
    input  logic [IDX_W-1:0]           rr_wr_idx,
    input  logic [BANK_W-1:0]          rr_wr_val
);
    logic [TAG_W-1:0]            tag_mem  [NB][NL];
    logic [LINE_W-1:0]           data_mem [NB][NL];
    logic [NB-1:0][NL-1:0]       vld;
    logic [NL-1:0][BANK_W-1:0]   rr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld <= '0;
            rr  <= '0;
        end else begin
            if (wr_en)    vld[wr_bank][wr_idx] <= 1'b1;
            if (rr_wr_en) rr[rr_wr_idx] <= rr_wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_bank][wr_idx]  <= wr_tag;
            data_mem[wr_bank][wr_idx] <= wr_line;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_rd
        assign rd_valid[b] = vld[b][rd_idx];
        assign rd_tag[b]   = tag_mem[b][rd_idx];
        assign rd_line[b]  = data_mem[b][rd_idx];
    end

    assign rr_rd_val = rr[rr_rd_idx];
endmodule

// File: rtl/ic_lookup.sv
module ic_lookup
    import icache_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  geom_t                     geom,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NB-1:0]             rd_valid,
    input  logic [NB-1:0][TAG_W-1:0]  rd_tag,
    output logic                      hit,
    output logic [BANK_W-1:0]         hit_bank
);
    logic [1:0]        concat_lg;
    logic [1:0]        cmask;
    logic [1:0]        smask;
    logic [BANK_W-1:0] addr_bsel;
    logic [NB-1:0]     hit_vec;

    assign concat_lg = geom.size_lg - geom.ways_lg;
    assign cmask     = lg_mask(concat_lg);
    assign smask     = lg_mask(geom.size_lg);
    assign addr_bsel = addr[TAG_LSB +: BANK_W];

    for (genvar b = 0; b < NB; b++) begin : g_cmp
        localparam logic [BANK_W-1:0] BID = BANK_W'(b);
        logic active, cand;
        assign active = ((BID & ~smask) == '0);
        assign cand   = active && ((BID & cmask) == (addr_bsel & cmask));
        assign hit_vec[b] = cand && rd_valid[b] &&
                            (rd_tag[b] == addr[ADDR_W-1:TAG_LSB]);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_bank = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if (hit_vec[b]) hit_bank = BANK_W'(b);
        end
    end
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
    import icache_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  geom_t                geom,
    input  logic                 fetch_valid,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 cfg_write,
    output logic                 fetch_ready,
    input  logic                 hit,
    input  logic [LINE_W-1:0]    hit_line,
    output logic [IDX_W-1:0]     rr_rd_idx,
    input  logic [BANK_W-1:0]    rr_rd_val,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [WORD_W-1:0]    resp_data,
    output logic                 mem_req_valid,
    output logic [ADDR_W-1:0]    mem_req_addr,
    input  logic                 mem_resp_valid,
    input  logic [LINE_W-1:0]    mem_resp_data,
    output logic                 wr_en,
    output logic [BANK_W-1:0]    wr_bank,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [TAG_W-1:0]     wr_tag,
    output logic                 rr_wr_en,
    output logic [IDX_W-1:0]     rr_wr_idx,
    output logic [BANK_W-1:0]    rr_wr_val,
    output logic                 ev_hit,
    output logic                 ev_miss
);
    ctl_state_e        state;
    logic [ADDR_W-1:0] req_addr;
    logic [SUB_W-1:0]  sub;
    logic [BANK_W-1:0] victim;
    logic [WORD_W-1:0] crit_word;

    logic              accept;
    logic [SUB_W-1:0]  sub_mask;
    logic [1:0]        wmask;
    logic [1:0]        cmask;
    logic [PL_W-1:0]   base_pl;
    logic [PL_W-1:0]   cur_pl;
    logic [SUB_W-1:0]  crit_sub;
    logic              last_beat;
    logic [WORD_W-1:0] beat_word;
    logic [WORD_W-1:0] hit_word;

    assign sub_mask = lg_mask(geom.line_lg);
    assign wmask    = lg_mask(geom.ways_lg);
    assign cmask    = lg_mask(geom.size_lg - geom.ways_lg);

    assign fetch_ready = (state == ST_IDLE);
    assign accept      = fetch_valid && fetch_ready && !cfg_write;
    assign ev_hit      = accept && hit;
    assign ev_miss     = accept && !hit;

    // Round-robin pointer lives at the first physical index of the logical line.
    assign rr_rd_idx = fetch_addr[OFF_W +: IDX_W] & ~IDX_W'(sub_mask);

    assign base_pl   = req_addr[ADDR_W-1:OFF_W] & ~PL_W'(sub_mask);
    assign cur_pl    = base_pl | PL_W'(sub);
    assign crit_sub  = req_addr[OFF_W +: SUB_W] & sub_mask;
    assign last_beat = (sub == sub_mask);

    assign mem_req_valid = (state == ST_REFILL);
    assign mem_req_addr  = {cur_pl, {OFF_W{1'b0}}};

    assign wr_en   = mem_req_valid && mem_resp_valid;
    assign wr_idx  = cur_pl[IDX_W-1:0];
    assign wr_tag  = req_addr[ADDR_W-1:TAG_LSB];
    assign wr_bank = BANK_W'(victim << (geom.size_lg - geom.ways_lg)) |
                     (req_addr[TAG_LSB +: BANK_W] & cmask);

    assign rr_wr_en  = wr_en && last_beat;
    assign rr_wr_idx = wr_idx & ~IDX_W'(sub_mask);
    assign rr_wr_val = (victim + 1'b1) & wmask;

    assign beat_word = mem_resp_data[{req_addr[2 +: WSEL_W], 5'b0} +: WORD_W];
    assign hit_word  = hit_line[{fetch_addr[2 +: WSEL_W], 5'b0} +: WORD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
            req_addr   <= '0;
            sub        <= '0;
            victim     <= '0;
            crit_word  <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept && hit) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_data  <= hit_word;
                    end else if (accept) begin
                        state    <= ST_REFILL;
                        req_addr <= fetch_addr;
                        sub      <= '0;
                        victim   <= rr_rd_val & wmask;
                    end
                end
                ST_REFILL: begin
                    if (mem_resp_valid) begin
                        if (sub == crit_sub) crit_word <= beat_word;
                        if (last_beat) begin
                            state      <= ST_IDLE;
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b0;
                            resp_data  <= (sub == crit_sub) ? beat_word : crit_word;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ic_perf.sv
module ic_perf #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             ev_hit,
    input  logic             ev_miss,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (ev_hit)  hit_count  <= hit_count + 1'b1;
            if (ev_miss) miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_icache.sv
module cfg_icache
    import icache_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_write,
    input  logic [1:0]         cfg_size,
    input  logic [1:0]         cfg_ways,
    input  logic [1:0]         cfg_line,
    input  logic               fetch_valid,
    input  logic [ADDR_W-1:0]  fetch_addr,
    output logic               fetch_ready,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic [WORD_W-1:0]  resp_data,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_resp_valid,
    input  logic [LINE_W-1:0]  mem_resp_data,
    input  logic               cnt_clear,
    output logic [31:0]        hit_count,
    output logic [31:0]        miss_count
);
    geom_t                          geom;
    logic                           cfg_take;
    logic [NUM_BANKS-1:0]           rd_valid;
    logic [NUM_BANKS-1:0][TAG_W-1:0]  rd_tag;
    logic [NUM_BANKS-1:0][LINE_W-1:0] rd_line;
    logic [IDX_W-1:0]               rr_rd_idx, rr_wr_idx, wr_idx;
    logic [BANK_W-1:0]              rr_rd_val, rr_wr_val, wr_bank, hit_bank;
    logic [TAG_W-1:0]               wr_tag;
    logic                           wr_en, rr_wr_en, hit, ev_hit, ev_miss;

    assign cfg_take = cfg_write && fetch_ready;

    ic_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .take(cfg_take),
        .size_code(cfg_size), .ways_code(cfg_ways), .line_code(cfg_line),
        .geom(geom)
    );

    ic_store u_store (
        .clk(clk), .rst(rst), .flush(cfg_take),
        .rd_idx(fetch_addr[OFF_W +: IDX_W]),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line),
        .rr_rd_idx(rr_rd_idx), .rr_rd_val(rr_rd_val),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_line(mem_resp_data),
        .rr_wr_en(rr_wr_en), .rr_wr_idx(rr_wr_idx), .rr_wr_val(rr_wr_val)
    );

    ic_lookup u_lookup (
        .geom(geom), .addr(fetch_addr),
        .rd_valid(rd_valid), .rd_tag(rd_tag),
        .hit(hit), .hit_bank(hit_bank)
    );

    ic_ctrl u_ctrl (
        .clk(clk), .rst(rst), .geom(geom),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .cfg_write(cfg_write), .fetch_ready(fetch_ready),
        .hit(hit), .hit_line(rd_line[hit_bank]),
        .rr_rd_idx(rr_rd_idx), .rr_rd_val(rr_rd_val),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .rr_wr_en(rr_wr_en), .rr_wr_idx(rr_wr_idx), .rr_wr_val(rr_wr_val),
        .ev_hit(ev_hit), .ev_miss(ev_miss)
    );

    ic_perf u_perf (
        .clk(clk), .rst(rst), .clear(cnt_clear),
        .ev_hit(ev_hit), .ev_miss(ev_miss),
        .hit_count(hit_count), .miss_count(miss_count)
    );
endmodule

// File: rtl/cfg_icache_chk.sv
module cfg_icache_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_write,
    input logic        fetch_ready,
    input logic        resp_valid,
    input logic        resp_hit,
    input logic        mem_req_valid,
    input logic [31:0] mem_req_addr,
    input logic        mem_resp_valid,
    input logic        cnt_clear,
    input logic [31:0] hit_count,
    input logic [31:0] miss_count
);
    // R9
    hit_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit && !$past(cnt_clear)) |-> (hit_count == $past(hit_count) + 32'd1));

    // R9
    miss_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req_valid) && !$past(cnt_clear)) |-> (miss_count == $past(miss_count) + 32'd1));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && $past(mem_req_valid && !mem_resp_valid)) |-> $stable(mem_req_addr));

    // R4
    req_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && $past(mem_req_valid && mem_resp_valid)) |-> (mem_req_addr == $past(mem_req_addr) + 32'd16));

    // R8
    cfg_drops_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_write && fetch_ready) |-> !resp_valid);
endmodule

bind cfg_icache cfg_icache_chk u_chk (
    .clk(clk), .rst(rst), .cfg_write(cfg_write), .fetch_ready(fetch_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .cnt_clear(cnt_clear),
    .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/sim_cfg_icache.sv
`timescale 1ns/1ps
module sim_cfg_icache;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_write = 1'b0;
    logic [1:0]   cfg_size = '0, cfg_ways = '0, cfg_line = '0;
    logic         fetch_valid = 1'b0;
    logic [31:0]  fetch_addr = '0;
    logic         fetch_ready, resp_valid, resp_hit;
    logic [31:0]  resp_data;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_resp_valid = 1'b0;
    logic [127:0] mem_resp_data = '0;
    logic         cnt_clear = 1'b0;
    logic [31:0]  hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    int exp_hits = 0;
    int exp_misses = 0;
    int rcount = 0;
    logic [31:0] rlog [0:15];

    always #2.5 clk = ~clk;

    cfg_icache u0 (
        .clk(clk), .rst(rst), .cfg_write(cfg_write),
        .cfg_size(cfg_size), .cfg_ways(cfg_ways), .cfg_line(cfg_line),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .cnt_clear(cnt_clear), .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [31:0] wdat(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h3C5A_0000;
    endfunction

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Memory model: answers each request two negedges after it appears.
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (mem_resp_valid) begin
                mem_resp_valid = 1'b0;
            end else if (mem_req_valid) begin
                lat++;
                if (lat == 2) begin
                    lat = 0;
                    mem_resp_data = {wdat(mem_req_addr + 32'd12), wdat(mem_req_addr + 32'd8),
                                     wdat(mem_req_addr + 32'd4), wdat(mem_req_addr)};
                    mem_resp_valid = 1'b1;
                    if (rcount < 16) rlog[rcount] = mem_req_addr;
                    rcount++;
                end
            end
        end
    end

    task automatic wait_resp(output bit got);
        got = 0;
        for (int i = 0; i < 200 && !got; i++) begin
            if (resp_valid) got = 1;
            else @(negedge clk);
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, input bit exp_hit, input string req);
        bit got;
        rcount = 0;
        @(negedge clk);
        while (!fetch_ready) @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        @(negedge clk);
        fetch_valid = 1'b0;
        wait_resp(got);
        if (exp_hit) exp_hits++; else exp_misses++;
        check(got, {req, " response seen"}, 32'(got), 32'd1);
        check(resp_hit == exp_hit, {req, " hit flag"}, 32'(resp_hit), 32'(exp_hit));
        check(resp_data == wdat(a), {req, " data"}, resp_data, wdat(a));
    endtask

    task automatic set_cfg(input logic [1:0] s, input logic [1:0] w, input logic [1:0] l);
        @(negedge clk);
        while (!fetch_ready) @(negedge clk);
        cfg_write = 1'b1; cfg_size = s; cfg_ways = w; cfg_line = l;
        @(negedge clk);
        cfg_write = 1'b0;
    endtask

    task automatic t_reset();
        // R1 reset values
        check(fetch_ready == 1'b1, "R1 ready after reset", 32'(fetch_ready), 32'd1);
        check(resp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 idle outputs",
              {30'd0, resp_valid, mem_req_valid}, 32'd0);
        check(hit_count == 0 && miss_count == 0, "R1 counters zero", hit_count | miss_count, 32'd0);
    endtask

    task automatic t_base();
        // R1 base geometry, R2 hit, R3 miss
        do_fetch(32'h0000_0108, 1'b0, "R3 cold miss");
        check(rcount == 1, "R3 single beat", 32'(rcount), 32'd1);
        check(rlog[0] == 32'h0000_0100, "R3 aligned request", rlog[0], 32'h100);
        do_fetch(32'h0000_010C, 1'b1, "R2 hit other word");
        do_fetch(32'h0000_0100, 1'b1, "R2 hit word 0");
        do_fetch(32'h0000_0904, 1'b0, "R1 conflict miss");
        do_fetch(32'h0000_0100, 1'b0, "R1 evicted by 2KB direct-mapped");
        check(hit_count == 32'(exp_hits), "R9 hit count", hit_count, 32'(exp_hits));
        check(miss_count == 32'(exp_misses), "R9 miss count", miss_count, 32'(exp_misses));
    endtask

    task automatic t_clear();
        // R10 counter clear
        @(negedge clk); cnt_clear = 1'b1;
        @(negedge clk); cnt_clear = 1'b0;
        exp_hits = 0; exp_misses = 0;
        check(hit_count == 0 && miss_count == 0, "R10 cleared", hit_count | miss_count, 32'd0);
        do_fetch(32'h0000_0104, 1'b1, "R10 hit after clear");
        check(hit_count == 32'd1 && miss_count == 32'd0, "R10 count restarts",
              hit_count + (miss_count << 8), 32'd1);
    endtask

    task automatic t_line();
        // R4 line lengths
        set_cfg(2'd0, 2'd0, 2'd2);
        do_fetch(32'h0000_1028, 1'b0, "R4 64B miss");
        check(rcount == 4, "R4 four beats", 32'(rcount), 32'd4);
        for (int i = 0; i < 4; i++)
            check(rlog[i] == 32'h1000 + 32'(16 * i), "R4 ascending beat", rlog[i], 32'h1000 + 32'(16 * i));
        do_fetch(32'h0000_1004, 1'b1, "R4 first part hits");
        do_fetch(32'h0000_103C, 1'b1, "R4 last part hits");
        set_cfg(2'd0, 2'd0, 2'd1);
        do_fetch(32'h0000_2034, 1'b0, "R4 32B miss");
        check(rcount == 2 && rlog[0] == 32'h2020 && rlog[1] == 32'h2030,
              "R4 32B beats", rlog[0], 32'h2020);
        do_fetch(32'h0000_2020, 1'b1, "R4 32B low half hits");
        do_fetch(32'h0000_2040, 1'b0, "R4 next line misses");
    endtask

    task automatic t_cfg_flush();
        bit got;
        // R8 invalidation on write
        set_cfg(2'd0, 2'd0, 2'd1);
        do_fetch(32'h0000_2024, 1'b0, "R8 invalidated by cfg write");
        // R8 same-cycle fetch dropped
        rcount = 0;
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 32'h0000_2024;
        cfg_write = 1'b1; cfg_size = 2'd0; cfg_ways = 2'd0; cfg_line = 2'd1;
        @(negedge clk);
        fetch_valid = 1'b0; cfg_write = 1'b0;
        got = 0;
        for (int i = 0; i < 6; i++) begin
            if (resp_valid || mem_req_valid) got = 1;
            @(negedge clk);
        end
        check(!got && rcount == 0, "R8 same-cycle fetch dropped", 32'(got), 32'd0);
        do_fetch(32'h0000_2024, 1'b0, "R8 flushed before drop");
    endtask

    task automatic t_size();
        // R5 4KB direct-mapped
        set_cfg(2'd1, 2'd0, 2'd0);
        do_fetch(32'h0000_0000, 1'b0, "R5 4KB fill a");
        do_fetch(32'h0000_0800, 1'b0, "R5 4KB fill b");
        do_fetch(32'h0000_0000, 1'b1, "R5 4KB a kept");
        do_fetch(32'h0000_0800, 1'b1, "R5 4KB b kept");
        do_fetch(32'h0000_1000, 1'b0, "R5 4KB c conflicts a");
        do_fetch(32'h0000_0804, 1'b1, "R5 4KB b survives");
        do_fetch(32'h0000_0000, 1'b0, "R5 4KB a evicted");
        // R5 8KB direct-mapped
        set_cfg(2'd2, 2'd0, 2'd0);
        for (int i = 0; i < 4; i++) do_fetch(32'(i) * 32'h800, 1'b0, "R5 8KB fill");
        for (int i = 0; i < 4; i++) do_fetch(32'(i) * 32'h800 + 32'd8, 1'b1, "R5 8KB all kept");
        do_fetch(32'h0000_2000, 1'b0, "R5 8KB fifth");
        do_fetch(32'h0000_0800, 1'b1, "R5 8KB bank1 survives");
        do_fetch(32'h0000_0000, 1'b0, "R5 8KB bank0 evicted");
    endtask

    task automatic t_ways();
        // R6 R7 2-way round robin
        set_cfg(2'd1, 2'd1, 2'd0);
        do_fetch(32'h0000_0000, 1'b0, "R7 2w fill way0");
        do_fetch(32'h0000_0800, 1'b0, "R7 2w fill way1");
        do_fetch(32'h0000_0000, 1'b1, "R6 2w a hit");
        do_fetch(32'h0000_0800, 1'b1, "R6 2w b hit");
        do_fetch(32'h0000_1000, 1'b0, "R7 2w evict way0");
        do_fetch(32'h0000_0800, 1'b1, "R7 2w b survives");
        do_fetch(32'h0000_0000, 1'b0, "R7 2w a gone");
        do_fetch(32'h0000_1000, 1'b1, "R7 2w c survives");
        do_fetch(32'h0000_0800, 1'b0, "R7 2w b evicted");
        // R6 R7 4-way
        set_cfg(2'd2, 2'd2, 2'd0);
        for (int i = 0; i < 4; i++) do_fetch(32'h40 + 32'(i) * 32'h800, 1'b0, "R6 4w fill");
        for (int i = 0; i < 4; i++) do_fetch(32'h44 + 32'(i) * 32'h800, 1'b1, "R6 4w all kept");
        do_fetch(32'h0000_2040, 1'b0, "R7 4w fifth");
        do_fetch(32'h0000_0840, 1'b1, "R7 4w way1 kept");
        do_fetch(32'h0000_0040, 1'b0, "R7 4w way0 evicted");
        do_fetch(32'h0000_0840, 1'b0, "R7 4w way1 next victim");
    endtask

    task automatic t_clamp();
        // R6 clamp at 2KB
        set_cfg(2'd0, 2'd2, 2'd0);
        do_fetch(32'h0000_0000, 1'b0, "R6 clamp fill");
        do_fetch(32'h0000_0800, 1'b0, "R6 clamp conflict");
        do_fetch(32'h0000_0000, 1'b0, "R6 clamp direct-mapped");
        // R4 R6 code 3 handling: 4KB, 2 ways, 64B
        set_cfg(2'd1, 2'd3, 2'd3);
        do_fetch(32'h0000_0000, 1'b0, "R4 code3 line fill");
        check(rcount == 4, "R4 code3 is 64B", 32'(rcount), 32'd4);
        do_fetch(32'h0000_0800, 1'b0, "R6 code3 way1");
        do_fetch(32'h0000_1000, 1'b0, "R6 code3 evict way0");
        do_fetch(32'h0000_0830, 1'b1, "R6 code3 two ways kept");
        do_fetch(32'h0000_0000, 1'b0, "R6 code3 a evicted");
    endtask

    task automatic t_busy_cfg();
        bit got;
        // R8 cfg write during refill ignored
        rcount = 0;
        @(negedge clk);
        while (!fetch_ready) @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 32'h0000_3008;
        @(negedge clk);
        fetch_valid = 1'b0;
        cfg_write = 1'b1; cfg_size = 2'd0; cfg_ways = 2'd0; cfg_line = 2'd0;
        @(negedge clk);
        cfg_write = 1'b0;
        wait_resp(got);
        exp_misses++;
        check(got && !resp_hit && resp_data == wdat(32'h3008), "R8 refill completes",
              resp_data, wdat(32'h3008));
        do_fetch(32'h0000_3030, 1'b1, "R8 busy cfg write ignored");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_base();
        t_clear();
        t_line();
        t_cfg_flush();
        t_size();
        t_ways();
        t_clamp();
        t_busy_cfg();
        // R9 totals since last clear
        check(hit_count == 32'(exp_hits), "R9 final hits", hit_count, 32'(exp_hits));
        check(miss_count == 32'(exp_misses), "R9 final misses", miss_count, 32'(exp_misses));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule